// File: doc/BRIEF.md
# Static Branch Steering Unit

This unit sits between the instruction decoder and the fetch address generator. For every decoded branch it forms the target address and decides from the displacement's sign whether fetch should jump there at once. Unconditional branches always jump. A conditional branch whose target lies at or below its own address is assumed to close a loop and is taken. A conditional branch whose target lies above it falls through, unless a user-writable mode bit asks for such branches to be taken as well.

The unit keeps a record of the most recent conditional branch it predicted. When the execute stage reports the real outcome of that branch and it disagrees with the guess, the unit raises a flush and steers fetch to the right address. That address is the fall-through address after a wrong taken guess, or the target after a wrong not-taken guess. A correction outranks any redirect wanted by a branch decoded in the same cycle. That younger branch lies on the wrong path and is dropped. All outputs are registered and appear one clock after the inputs that cause them.

Top module: `branchSteer`

## Requirements
- R1: While rstN is low and in the first cycle after it, redirValidO, flushO, predValidO and predTakenO are all 0.
- R2: A decoded unconditional branch (decValid=1, decUncond=1) with no correction pending gives, one clock later, predValidO=1, predTakenO=1, redirValidO=1 and flushO=0.
- R3: The displacement is decShortDisp sign-extended when that field is nonzero, and decExtDisp sign-extended when it is zero. The target is decPc + 2 + displacement, modulo 2^ADDR_W, and a redirect for a decoded branch carries this value on redirAddrO.
- R4: A conditional branch with displacement of -2 or less (target at or below decPc) is predicted taken and redirected, whatever fwdTakenMode is.
- R5: A conditional branch with displacement of -1 or more (target above decPc), decoded with fwdTakenMode=0, gives predValidO=1, predTakenO=0 and no redirect.
- R6: The same forward conditional branch decoded with fwdTakenMode=1 is predicted taken and redirected to its target.
- R7: A resolution (resValid=1) whose resTaken equals the recorded prediction raises neither flushO nor redirValidO.
- R8: A resolution with resTaken=0 for a branch predicted taken gives flushO=1 and redirValidO=1 one clock later. redirAddrO is then the fall-through address: decPc+2 for a nonzero short field, or decPc+4 when the extension word was used.
- R9: A resolution with resTaken=1 for a branch predicted not-taken gives flushO=1 and redirValidO=1, with redirAddrO equal to the recorded target.
- R10: When a mismatching resolution and a decoded branch arrive in the same cycle, the correction is output, predValidO stays 0, and the decoded branch is not recorded.
- R11: A resolution applies to the most recent recorded conditional branch only, and at most once. A resolution with nothing recorded has no effect. Unconditional branches are never recorded.
- R12: The strobes are single-cycle. A cycle with decValid=0 and resValid=0 is followed by all four strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| decValid | input | 1 | A branch is decoded this cycle |
| decUncond | input | 1 | 1 for an unconditional branch, 0 for a conditional one |
| decPc | input | ADDR_W | Address of the decoded branch |
| decShortDisp | input | SHORT_W | Displacement field in the opcode; zero selects the extension word |
| decExtDisp | input | EXT_W | Extension-word displacement |
| fwdTakenMode | input | 1 | User control bit 7: predict forward conditional branches taken |
| resValid | input | 1 | Outcome of the recorded conditional branch is available |
| resTaken | input | 1 | Actual outcome: 1 taken, 0 not taken |
| redirValidO | output | 1 | Redirect fetch this cycle |
| redirAddrO | output | ADDR_W | Fetch address for the redirect |
| flushO | output | 1 | Wrong-path instructions must be discarded |
| predValidO | output | 1 | A decoded branch was predicted |
| predTakenO | output | 1 | Predicted direction of that branch |

## Verification
If the recorded prediction bit is corrupted, a correct guess is flushed, or a wrong one is kept. This shows on flushO one clock after the resolution. A stale record-valid flag shows up as a flush for a resolution that should have been ignored. A wrong adder or sign extension puts a bad redirAddrO on the cycle after the decode, or only after a resolution when it affects the stored fall-through address. So the sweeps over every short displacement, both mode settings and both outcomes compare each output on the clock after every stimulus.

// File: rtl/branchSteerPkg.sv
package branchSteerPkg;

  // Strobes passed from the control FSM to the datapath each cycle
  typedef struct packed {
    logic issueRedir;  // drive a redirect next cycle
    logic issueFlush;  // drive a flush next cycle
    logic selCorrect;  // redirect address comes from the record
    logic reportPred;  // publish the decoded branch prediction
    logic loadRec;     // capture the decoded conditional branch
  } steerCtrl_t;

endpackage

// File: rtl/branchSteerTarget.sv
// Displacement selection, target and fall-through arithmetic, direction.
module branchSteerTarget #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 8,
  parameter int EXT_W   = 16
) (
  input  logic [ADDR_W-1:0]  pc,
  input  logic [SHORT_W-1:0] shortDisp,
  input  logic [EXT_W-1:0]   extDisp,
  output logic [ADDR_W-1:0]  target,
  output logic [ADDR_W-1:0]  fallThrough,
  output logic               isForward
);
  localparam int OPWORD_BYTES = 2;
  localparam int EXT_BYTES    = EXT_W / 8;
  localparam logic [ADDR_W-1:0] SHORT_STEP = ADDR_W'(OPWORD_BYTES);
  localparam logic [ADDR_W-1:0] LONG_STEP  = ADDR_W'(OPWORD_BYTES + EXT_BYTES);

  if (ADDR_W <= EXT_W) begin : gBadWidth
    $error("ADDR_W must exceed EXT_W");
  end

  logic              useExt;
  logic [ADDR_W-1:0] shortWide;
  logic [ADDR_W-1:0] extWide;
  logic [ADDR_W-1:0] disp;

  always_comb begin
    useExt    = (shortDisp == '0);
    shortWide = ADDR_W'($signed(shortDisp));
    extWide   = ADDR_W'($signed(extDisp));
    disp      = useExt ? extWide : shortWide;
    target      = pc + SHORT_STEP + disp;
    fallThrough = pc + (useExt ? LONG_STEP : SHORT_STEP);
    // target above pc  <=>  disp >= -1
    isForward = !disp[ADDR_W-1] || (disp == '1);
  end
endmodule

// File: rtl/branchSteerControl.sv
// Decides redirect, flush and recording; owns the record-valid flag.
module branchSteerControl
  import branchSteerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       decValid,
  input  logic       decUncond,
  input  logic       resValid,
  input  logic       resTaken,
  input  logic       predTakenNow,
  input  logic       recPredTaken,
  output steerCtrl_t ctrl
);
  logic recValid;
  logic consume;
  logic mispredict;
  logic acceptDec;

  always_comb begin
    consume    = resValid && recValid;
    mispredict = consume && (resTaken != recPredTaken);
    acceptDec  = decValid && !mispredict;

    ctrl.selCorrect = mispredict;
    ctrl.issueFlush = mispredict;
    ctrl.issueRedir = mispredict || (acceptDec && predTakenNow);
    ctrl.reportPred = acceptDec;
    ctrl.loadRec    = acceptDec && !decUncond;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= 1'b0;
    end else if (ctrl.loadRec) begin
      recValid <= 1'b1;
    end else if (consume) begin
      recValid <= 1'b0;
    end
  end
endmodule

// File: rtl/branchSteerDatapath.sv
// Prediction record, redirect address mux and output registers.
module branchSteerDatapath
  import branchSteerPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 8,
  parameter int EXT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  decPc,
  input  logic [SHORT_W-1:0] decShortDisp,
  input  logic [EXT_W-1:0]   decExtDisp,
  input  logic               decUncond,
  input  logic               fwdTakenMode,
  input  logic               resTaken,
  input  steerCtrl_t         ctrl,
  output logic               predTakenNow,
  output logic               recPredTaken,
  output logic               redirValidO,
  output logic [ADDR_W-1:0]  redirAddrO,
  output logic               flushO,
  output logic               predValidO,
  output logic               predTakenO
);
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] fallThrough;
  logic              isForward;
  logic [ADDR_W-1:0] recTarget;
  logic [ADDR_W-1:0] recFall;
  logic [ADDR_W-1:0] nextAddr;

  branchSteerTarget #(
    .ADDR_W (ADDR_W),
    .SHORT_W(SHORT_W),
    .EXT_W  (EXT_W)
  ) uTarget (
    .pc         (decPc),
    .shortDisp  (decShortDisp),
    .extDisp    (decExtDisp),
    .target     (target),
    .fallThrough(fallThrough),
    .isForward  (isForward)
  );

  always_comb begin
    predTakenNow = decUncond || !isForward || fwdTakenMode;
    if (ctrl.selCorrect) nextAddr = resTaken ? recTarget : recFall;
    else                 nextAddr = target;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirValidO  <= 1'b0;
      redirAddrO   <= '0;
      flushO       <= 1'b0;
      predValidO   <= 1'b0;
      predTakenO   <= 1'b0;
      recTarget    <= '0;
      recFall      <= '0;
      recPredTaken <= 1'b0;
    end else begin
      redirValidO <= ctrl.issueRedir;
      flushO      <= ctrl.issueFlush;
      predValidO  <= ctrl.reportPred;
      predTakenO  <= ctrl.reportPred && predTakenNow;
      if (ctrl.issueRedir) redirAddrO <= nextAddr;
      if (ctrl.loadRec) begin
        recTarget    <= target;
        recFall      <= fallThrough;
        recPredTaken <= predTakenNow;
      end
    end
  end
endmodule

// File: rtl/branchSteer.sv
module branchSteer
  import branchSteerPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 8,
  parameter int EXT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               decValid,
  input  logic               decUncond,
  input  logic [ADDR_W-1:0]  decPc,
  input  logic [SHORT_W-1:0] decShortDisp,
  input  logic [EXT_W-1:0]   decExtDisp,
  input  logic               fwdTakenMode,
  input  logic               resValid,
  input  logic               resTaken,
  output logic               redirValidO,
  output logic [ADDR_W-1:0]  redirAddrO,
  output logic               flushO,
  output logic               predValidO,
  output logic               predTakenO
);
  steerCtrl_t ctrl;
  logic       predTakenNow;
  logic       recPredTaken;

  branchSteerControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .decValid    (decValid),
    .decUncond   (decUncond),
    .resValid    (resValid),
    .resTaken    (resTaken),
    .predTakenNow(predTakenNow),
    .recPredTaken(recPredTaken),
    .ctrl        (ctrl)
  );

  branchSteerDatapath #(
    .ADDR_W (ADDR_W),
    .SHORT_W(SHORT_W),
    .EXT_W  (EXT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .decPc       (decPc),
    .decShortDisp(decShortDisp),
    .decExtDisp  (decExtDisp),
    .decUncond   (decUncond),
    .fwdTakenMode(fwdTakenMode),
    .resTaken    (resTaken),
    .ctrl        (ctrl),
    .predTakenNow(predTakenNow),
    .recPredTaken(recPredTaken),
    .redirValidO (redirValidO),
    .redirAddrO  (redirAddrO),
    .flushO      (flushO),
    .predValidO  (predValidO),
    .predTakenO  (predTakenO)
  );
endmodule

// File: rtl/branchSteerChk.sv
module branchSteerChk #(
  parameter int SHORT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               decValid,
  input logic               decUncond,
  input logic [SHORT_W-1:0] decShortDisp,
  input logic               fwdTakenMode,
  input logic               resValid,
  input logic               redirValidO,
  input logic               flushO,
  input logic               predValidO,
  input logic               predTakenO
);
  // R8
  flush_carries_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushO |-> (redirValidO && !predValidO));

  // R5
  not_taken_stays_put_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predValidO && !predTakenO) |-> !redirValidO);

  // R2
  uncond_jumps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && decUncond && !resValid) |=>
      (redirValidO && predTakenO && predValidO && !flushO));

  // R4
  backward_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decUncond && !resValid && decShortDisp[SHORT_W-1] &&
     (decShortDisp != '1)) |=> (predTakenO && redirValidO));

  // R5
  forward_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decUncond && !resValid && !fwdTakenMode &&
     (decShortDisp != '0) && !decShortDisp[SHORT_W-1]) |=> !redirValidO);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!decValid && !resValid) |=> (!redirValidO && !predValidO && !flushO));
endmodule

bind branchSteer branchSteerChk #(.SHORT_W(SHORT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .decValid    (decValid),
  .decUncond   (decUncond),
  .decShortDisp(decShortDisp),
  .fwdTakenMode(fwdTakenMode),
  .resValid    (resValid),
  .redirValidO (redirValidO),
  .flushO      (flushO),
  .predValidO  (predValidO),
  .predTakenO  (predTakenO)
);

// File: tb/branchSteer_test.sv
`timescale 1ns/1ps
module branchSteer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        decValid = 1'b0;
  logic        decUncond = 1'b0;
  logic [31:0] decPc = '0;
  logic [7:0]  decShortDisp = '0;
  logic [15:0] decExtDisp = '0;
  logic        fwdTakenMode = 1'b0;
  logic        resValid = 1'b0;
  logic        resTaken = 1'b0;
  logic        redirValidO;
  logic [31:0] redirAddrO;
  logic        flushO;
  logic        predValidO;
  logic        predTakenO;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // model of the prediction record
  bit          mPend = 1'b0;
  bit          mPred = 1'b0;
  logic [31:0] mTgt = '0;
  logic [31:0] mFall = '0;

  always #10 clk = ~clk;

  branchSteer uut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decUncond(decUncond),
    .decPc(decPc), .decShortDisp(decShortDisp), .decExtDisp(decExtDisp),
    .fwdTakenMode(fwdTakenMode), .resValid(resValid), .resTaken(resTaken),
    .redirValidO(redirValidO), .redirAddrO(redirAddrO), .flushO(flushO),
    .predValidO(predValidO), .predTakenO(predTakenO)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, then check the registered result.
  task automatic step(input bit dv, input bit unc, input logic [31:0] pc,
                      input logic [7:0] sd, input logic [15:0] ed,
                      input bit mode, input bit rv, input bit rt);
    logic [31:0] disp, tgt, fall, eAddr;
    bit fwd, pred, mis, eRed, eFl, ePv, ePt;
    string tag;
    disp = (sd != 0) ? {{24{sd[7]}}, sd} : {{16{ed[15]}}, ed};
    tgt  = pc + 32'd2 + disp;
    fall = pc + ((sd != 0) ? 32'd2 : 32'd4);
    fwd  = ($signed(disp) >= -1);
    pred = unc || !fwd || mode;
    mis  = rv && mPend && (rt != mPred);
    eRed = 0; eFl = 0; ePv = 0; ePt = 0; eAddr = '0;
    if (mis) begin
      eRed = 1; eFl = 1; eAddr = rt ? mTgt : mFall;
      tag = dv ? "R10" : (mPred ? "R8" : "R9");
    end else if (dv) begin
      ePv = 1; ePt = pred; eRed = pred; eAddr = tgt;
      if (rv && mPend) tag = "R7";
      else if (unc) tag = "R2";
      else if (!fwd) tag = "R4";
      else tag = mode ? "R6" : "R5";
    end else if (rv) begin
      tag = mPend ? "R7" : "R11";
    end else begin
      tag = "R12";
    end
    // model record update
    if (rv && mPend) mPend = 0;
    if (!mis && dv && !unc) begin
      mPend = 1; mPred = pred; mTgt = tgt; mFall = fall;
    end
    decValid = dv; decUncond = unc; decPc = pc; decShortDisp = sd;
    decExtDisp = ed; fwdTakenMode = mode; resValid = rv; resTaken = rt;
    @(negedge clk);
    decValid = 0; resValid = 0;
    chk(tag, "redirValid", 32'(redirValidO), 32'(eRed));
    chk(tag, "flush", 32'(flushO), 32'(eFl));
    chk(tag, "predValid", 32'(predValidO), 32'(ePv));
    chk(tag, "predTaken", 32'(predTakenO), 32'(ePt));
    if (eRed && redirValidO) chk(mis ? tag : "R3", "redirAddr", redirAddrO, eAddr);
  endtask

  task automatic idle();
    step(0, 0, '0, 8'h01, '0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1", "redirValid", 32'(redirValidO), 0);
    chk("R1", "flush", 32'(flushO), 0);
    chk("R1", "predValid", 32'(predValidO), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "predTaken", 32'(predTakenO), 0);
    chk("R1", "redirValid after", 32'(redirValidO), 0);

    // R2 R3: unconditional, every short displacement
    for (int s = 1; s < 256; s++) begin
      step(1, 1, 32'h0000_4000 + 32'(s * 6), 8'(s), 16'h0, s[0], 0, 0);
      if (s % 16 == 0) idle();
    end
    // R3: extension-word displacements, including address wrap
    for (int k = 0; k < 256; k++) begin
      step(1, 1, k[0] ? 32'hFFFF_FF80 : 32'h0000_0040, 8'h00,
           16'(k * 389 + 7), 0, 0, 0);
    end
    // R4 R5 R6 R7 R8 R9: conditional sweep, both modes and both outcomes
    for (int m = 0; m < 2; m++) begin
      for (int s = 1; s < 256; s++) begin
        for (int o = 0; o < 2; o++) begin
          step(1, 0, 32'h0001_0000 + 32'(s * 4), 8'(s), 16'h0, m[0], 0, 0);
          step(0, 0, '0, 8'h01, '0, 0, 1, o[0]);
        end
      end
    end
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 64; k++) begin
        for (int o = 0; o < 2; o++) begin
          step(1, 0, 32'h0002_0000 + 32'(k * 8), 8'h00, 16'(k * 1031),
               m[0], 0, 0);
          step(0, 0, '0, 8'h01, '0, 0, 1, o[0]);
        end
      end
    end
    // extension-word displacement of -2 (backward) and -1 (forward)
    step(1, 0, 32'h0000_0800, 8'h00, 16'hFFFE, 0, 0, 0);
    step(0, 0, '0, 8'h01, '0, 0, 1, 0);
    step(1, 0, 32'h0000_0800, 8'h00, 16'hFFFF, 0, 0, 0);
    step(0, 0, '0, 8'h01, '0, 0, 1, 1);

    // R10: correction and a new decode in the same cycle
    step(1, 0, 32'h0000_9000, 8'hF0, '0, 0, 0, 0);      // backward, taken
    step(1, 0, 32'h0000_A000, 8'hE0, '0, 0, 1, 0);      // mismatch wins
    step(0, 0, '0, 8'h01, '0, 0, 1, 1);                 // R11 nothing recorded
    // matching resolution with a new decode: the new branch is recorded
    step(1, 0, 32'h0000_9100, 8'h10, '0, 0, 0, 0);      // forward, not taken
    step(1, 0, 32'h0000_9200, 8'hC0, '0, 0, 1, 0);      // R7, new one taken
    step(0, 0, '0, 8'h01, '0, 0, 1, 0);                 // mismatch on newest
    // R11: newest branch wins, resolution only once, uncond not recorded
    step(1, 0, 32'h0000_B000, 8'h20, '0, 0, 0, 0);
    step(1, 0, 32'h0000_B100, 8'h80, '0, 0, 0, 0);
    step(0, 0, '0, 8'h01, '0, 0, 1, 1);                 // matches newest
    step(0, 0, '0, 8'h01, '0, 0, 1, 0);                 // already consumed
    step(1, 1, 32'h0000_C000, 8'h40, '0, 0, 0, 0);
    step(0, 0, '0, 8'h01, '0, 0, 1, 0);                 // ignored
    idle();
    idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule